// File: doc/BRIEF.md
# Predicated Result-Test Write Gate

This block steers the write-back of a vector loop in which every element result is tested before it reaches the register file. The loop is started with a length, a destination register base, a condition-field base, a predicate mask and a small configuration word. After that, one element per cycle arrives over a valid/ready input. Each element carries its computed data value and the four-bit condition field derived from that value. The gate then decides three things for the element: whether the data is written, whether zero is written in its place, and whether the condition field is recorded.

The test picks one condition bit and compares it with an invert flag, the same way a conditional branch does. A failing element has only its data write cancelled. The loop always runs to its full length. The condition field is recorded whenever recording or compare-only is selected, whatever the test outcome. A single zeroing flag controls both source and destination zeroing. Under zeroing, elements that are masked out or fail the test get a zero written to their destination register. In compare-only mode the element works like a compare: its data never reaches the register file.

The condition field is held as `cond[3:0]` = {LT, GT, EQ, SO}. A bit-select code of 0, 1, 2 or 3 picks LT (`cond[3]`), GT (`cond[2]`), EQ (`cond[1]`) or SO (`cond[0]`). All write outputs are registered and appear in the cycle after the element is accepted.

Top module: `pred_result_gate`

## Requirements
- R1: An element whose predicate bit (bit i of `pmask` for element i) is 0 produces no condition write, and with zeroing off it produces no register write either.
- R2: With `rec` or `cmp_only` set, every unmasked element writes its condition field (`cr_wdata` = `in_cond`) to index `cr_base + i`, modulo 2^CIDX_W, whether or not its test passes.
- R3: An unmasked element passes when the selected condition bit differs from `inv`, so a set bit passes with `inv`=0 and a clear bit passes with `inv`=1. A passing element outside compare-only mode writes `in_data` to register `reg_base + i`, modulo 2^RIDX_W.
- R4: An unmasked element that fails the test, with zeroing off, produces no register write.
- R5: In compare-only mode no register write occurs for any element, with or without zeroing.
- R6: With `zero` set and compare-only off, an element that is masked out or fails the test writes zero to register `reg_base + i`. A masked-out element still writes no condition field.
- R7: A loop always handles exactly `vl` elements, with `vl` clamped to MAX_VL. It then pulses `done` for one cycle with `done_vl` equal to that length, whatever the test results. For `vl`=0, `done` pulses in the cycle after `start` and no element is accepted.
- R8: `in_ready` is high exactly while a loop is in progress. One element is accepted per cycle in which `in_valid` and `in_ready` are both high. Its writes appear in the next cycle, and `start` is ignored while busy.
- R9: With `rec` and `cmp_only` both clear, no condition write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop; configuration is latched on this cycle when idle |
| vl | input | VLW | Loop length |
| reg_base | input | RIDX_W | Destination register base index |
| cr_base | input | CIDX_W | Condition-field base index |
| pmask | input | MAX_VL | Predicate mask, bit i for element i |
| sel_bit | input | 2 | Tested bit: 0 LT, 1 GT, 2 EQ, 3 SO |
| inv | input | 1 | Test invert flag |
| rec | input | 1 | Record condition fields |
| cmp_only | input | 1 | Compare-only mode |
| zero | input | 1 | Zeroing flag (source and destination) |
| in_valid | input | 1 | Element valid |
| in_ready | output | 1 | Element accepted when high with in_valid |
| in_data | input | DATA_W | Element result value |
| in_cond | input | 4 | Element condition field {LT,GT,EQ,SO} |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | RIDX_W | Register write index |
| rf_wdata | output | DATA_W | Register write data |
| cr_we | output | 1 | Condition-field write enable |
| cr_idx | output | CIDX_W | Condition-field write index |
| cr_wdata | output | 4 | Condition-field write data |
| done | output | 1 | One-cycle end-of-loop pulse |
| done_vl | output | VLW | Loop length reported with done |

## Verification
A wrong element counter shows up at once as a wrong write index, or as a mask bit read against the wrong element. It also moves the end of the loop, so `done` and `in_ready` fall in the wrong cycle. A stale configuration bit or a wrong test polarity changes `rf_we`, `rf_wdata` or `cr_we` in the cycle after the first element that reaches the bad decision. The reference model is compared on every cycle, so each such fault is caught within one clock of the faulty element.

// File: rtl/pred_result_gate.sv
module pred_result_gate #(
  parameter int DATA_W = 16,
  parameter int MAX_VL = 16,
  parameter int RIDX_W = 7,
  parameter int CIDX_W = 6,
  localparam int IW  = $clog2(MAX_VL),
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    vl,
  input  logic [RIDX_W-1:0] reg_base,
  input  logic [CIDX_W-1:0] cr_base,
  input  logic [MAX_VL-1:0] pmask,
  input  logic [1:0]        sel_bit,
  input  logic              inv,
  input  logic              rec,
  input  logic              cmp_only,
  input  logic              zero,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [3:0]        in_cond,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_idx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              cr_we,
  output logic [CIDX_W-1:0] cr_idx,
  output logic [3:0]        cr_wdata,
  output logic              done,
  output logic [VLW-1:0]    done_vl
);

  logic              busy_q;
  logic [IW-1:0]     cnt_q;
  logic [VLW-1:0]    vl_q;
  logic [RIDX_W-1:0] rb_q;
  logic [CIDX_W-1:0] cb_q;
  logic [MAX_VL-1:0] pm_q;
  logic [1:0]        sel_q;
  logic              inv_q, rec_q, cmp_q, zero_q;

  logic [VLW-1:0] vl_eff;
  assign vl_eff = (vl > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl;

  logic accept, last, pm, tbit, pass;
  assign in_ready = busy_q;
  assign accept   = busy_q && in_valid;
  assign last     = (VLW'(cnt_q) + VLW'(1)) == vl_q;
  assign pm       = pm_q[cnt_q];
  assign tbit     = cmp_q ? in_cond[1] : in_cond[2'd3 - sel_q];
  assign pass     = tbit ^ inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      vl_q     <= '0;
      rb_q     <= '0;
      cb_q     <= '0;
      pm_q     <= '0;
      sel_q    <= '0;
      inv_q    <= 1'b0;
      rec_q    <= 1'b0;
      cmp_q    <= 1'b0;
      zero_q   <= 1'b0;
      rf_we    <= 1'b0;
      rf_idx   <= '0;
      rf_wdata <= '0;
      cr_we    <= 1'b0;
      cr_idx   <= '0;
      cr_wdata <= '0;
      done     <= 1'b0;
      done_vl  <= '0;
    end else begin
      rf_we <= 1'b0;
      cr_we <= 1'b0;
      done  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          vl_q   <= vl_eff;
          rb_q   <= reg_base;
          cb_q   <= cr_base;
          pm_q   <= pmask;
          sel_q  <= sel_bit;
          inv_q  <= inv;
          rec_q  <= rec;
          cmp_q  <= cmp_only;
          zero_q <= zero;
          cnt_q  <= '0;
          if (vl_eff == '0) begin
            done    <= 1'b1;
            done_vl <= '0;
          end else begin
            busy_q <= 1'b1;
          end
        end
      end else if (accept) begin
        cr_we    <= pm && (rec_q || cmp_q);
        cr_idx   <= cb_q + CIDX_W'(cnt_q);
        cr_wdata <= in_cond;
        rf_idx   <= rb_q + RIDX_W'(cnt_q);
        if (!cmp_q) begin
          if (pm && pass) begin
            rf_we    <= 1'b1;
            rf_wdata <= in_data;
          end else if (zero_q) begin
            rf_we    <= 1'b1;
            rf_wdata <= '0;
          end
        end
        if (last) begin
          busy_q  <= 1'b0;
          done    <= 1'b1;
          done_vl <= vl_q;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + IW'(1);
        end
      end
    end
  end

  AST_MASKED_NO_CR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pm) |=> !cr_we); // R1
  AST_RECORD_CR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pm && (rec_q || cmp_q)) |=> (cr_we && cr_wdata == $past(in_cond))); // R2
  AST_PASS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pm && pass && !cmp_q) |=> (rf_we && rf_wdata == $past(in_data))); // R3
  AST_CMP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmp_q) |=> !rf_we); // R5
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmp_q && zero_q && !(pm && pass)) |=> (rf_we && rf_wdata == '0)); // R6

endmodule

// File: tb/tb_pred_result_gate.sv
module tb_pred_result_gate;
  localparam int DATA_W = 16;
  localparam int MAX_VL = 16;
  localparam int RIDX_W = 7;
  localparam int CIDX_W = 6;
  localparam int VLW = $clog2(MAX_VL + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, inv, rec, cmp_only, zero, in_valid, in_ready;
  logic [VLW-1:0] vl, done_vl;
  logic [RIDX_W-1:0] reg_base, rf_idx;
  logic [CIDX_W-1:0] cr_base, cr_idx;
  logic [MAX_VL-1:0] pmask;
  logic [1:0] sel_bit;
  logic [DATA_W-1:0] in_data, rf_wdata;
  logic [3:0] in_cond, cr_wdata;
  logic rf_we, cr_we, done;

  pred_result_gate #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .RIDX_W(RIDX_W), .CIDX_W(CIDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .reg_base(reg_base), .cr_base(cr_base),
    .pmask(pmask), .sel_bit(sel_bit), .inv(inv), .rec(rec), .cmp_only(cmp_only), .zero(zero),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_cond(in_cond),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata), .cr_we(cr_we), .cr_idx(cr_idx),
    .cr_wdata(cr_wdata), .done(done), .done_vl(done_vl));

  int checks = 0, fails = 0;
  string cur_req = "R8";

  // reference model state
  bit m_busy; int m_cnt, m_vl, m_rb, m_cb, m_sel; bit [MAX_VL-1:0] m_pm;
  bit m_inv, m_rec, m_cmp, m_zero;
  bit e_rf_we, e_cr_we, e_done; int e_rf_idx, e_cr_idx, e_done_vl;
  logic [DATA_W-1:0] e_rf_data; logic [3:0] e_cr_data;

  always @(posedge clk) begin
    e_rf_we = 0; e_cr_we = 0; e_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (in_valid) begin
        bit pmb, tb, ps;
        pmb = m_pm[m_cnt];
        tb  = m_cmp ? in_cond[1] : in_cond[3 - m_sel];
        ps  = tb ^ m_inv;
        e_cr_we = pmb && (m_rec || m_cmp);
        e_cr_idx = (m_cb + m_cnt) % (1 << CIDX_W);
        e_cr_data = in_cond;
        e_rf_idx = (m_rb + m_cnt) % (1 << RIDX_W);
        if (!m_cmp && pmb && ps) begin e_rf_we = 1; e_rf_data = in_data; end
        else if (!m_cmp && m_zero) begin e_rf_we = 1; e_rf_data = '0; end
        m_cnt++;
        if (m_cnt == m_vl) begin m_busy = 0; e_done = 1; e_done_vl = m_vl; end
      end
    end else if (start) begin
      m_vl = (int'(vl) > MAX_VL) ? MAX_VL : int'(vl);
      m_rb = reg_base; m_cb = cr_base; m_pm = pmask; m_sel = sel_bit;
      m_inv = inv; m_rec = rec; m_cmp = cmp_only; m_zero = zero; m_cnt = 0;
      if (m_vl == 0) begin e_done = 1; e_done_vl = 0; end else m_busy = 1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R8", "in_ready", in_ready, m_busy);
    chk(cur_req, "rf_we", rf_we, e_rf_we);
    if (e_rf_we) begin
      chk(cur_req, "rf_idx", rf_idx, e_rf_idx);
      chk(cur_req, "rf_wdata", rf_wdata, e_rf_data);
    end
    chk(cur_req, "cr_we", cr_we, e_cr_we);
    if (e_cr_we) begin
      chk("R2", "cr_idx", cr_idx, e_cr_idx);
      chk("R2", "cr_wdata", cr_wdata, e_cr_data);
    end
    chk("R7", "done", done, e_done);
    if (e_done) chk("R7", "done_vl", done_vl, e_done_vl);
  end

  task automatic run(input string req, input int n, input bit [MAX_VL-1:0] msk, input int sel,
                     input bit iv, input bit rc, input bit cm, input bit zr,
                     input int rb, input int cb, input int seed);
    @(negedge clk);
    cur_req = req;
    start = 1; vl = VLW'(n); pmask = msk; sel_bit = 2'(sel); inv = iv; rec = rc;
    cmp_only = cm; zero = zr; reg_base = RIDX_W'(rb); cr_base = CIDX_W'(cb);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < n; i++) begin
      if ((i + seed) % 4 == 3) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_data = DATA_W'(seed * 16'h1000 + i + 1);
      in_cond = 4'((i * 7 + seed) & 15);
      @(negedge clk);
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; vl = '0; reg_base = '0; cr_base = '0; pmask = '0; sel_bit = '0;
    inv = 0; rec = 0; cmp_only = 0; zero = 0; in_valid = 0; in_data = '0; in_cond = '0;
    repeat (3) @(negedge clk);
    chk("R8", "reset in_ready", in_ready, 0);
    chk("R7", "reset done", done, 0);
    chk("R3", "reset rf_we", rf_we, 0);
    chk("R2", "reset cr_we", cr_we, 0);
    rst_n = 1;
    run("R3", 8, '1, 0, 0, 1, 0, 0, 10, 4, 1);
    run("R3", 9, '1, 3, 1, 1, 0, 0, 20, 8, 2);
    run("R4", 12, 16'hA5A5, 2, 0, 1, 0, 0, 0, 0, 3);
    run("R1", 10, 16'h0000, 1, 0, 1, 0, 0, 5, 5, 4);
    run("R6", 16, 16'h0F0F, 1, 0, 1, 0, 1, 120, 60, 5);
    run("R6", 11, 16'h3C3C, 0, 1, 0, 0, 1, 1, 2, 6);
    run("R5", 10, 16'hF0F3, 2, 0, 0, 1, 1, 30, 30, 7);
    run("R5", 6, '1, 0, 1, 1, 1, 0, 40, 10, 8);
    run("R9", 8, '1, 2, 1, 0, 0, 1, 50, 12, 9);
    run("R7", 0, '1, 0, 0, 1, 0, 0, 0, 0, 10);
    run("R7", 16, '1, 2, 1, 1, 0, 1, 126, 62, 11);
    run("R7", 20, 16'h7FFE, 3, 0, 1, 0, 1, 3, 3, 12);
    // start pulsed while busy must be ignored
    @(negedge clk);
    cur_req = "R8";
    start = 1; vl = 4; pmask = '1; sel_bit = 0; inv = 0; rec = 1; cmp_only = 0; zero = 0;
    reg_base = 7; cr_base = 7;
    @(negedge clk);
    vl = 2; reg_base = 90; rec = 0;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 4; i++) begin
      in_valid = 1; in_data = DATA_W'(16'hBEE0 + i); in_cond = 4'(15 - i);
      @(negedge clk);
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule